// File: doc/BRIEF.md
# Shared-Latch Wide Timer Register Bridge

This block lets a CPU with an 8-bit data bus reach four 16-bit timer registers: a free-running counter, two compare registers and a capture register. Each wide register sits at two byte addresses, one for its upper byte and one for its lower byte. A single 8-bit holding latch is shared by all four registers. Software writes the upper byte first, which only fills the latch. The lower-byte write then commits both halves together in one clock edge. For reads, software reads the lower byte first, which snapshots the upper byte into the latch, and then reads the upper byte from the latch.

The two compare registers are an exception on the read side. Their reads bypass the latch: the upper-byte address returns the register's own upper byte, and a lower-byte read leaves the latch untouched. Because only one latch exists, any wide access to another register between the two halves of a sequence overwrites it. The bridge keeps that behaviour as it is; software guarantees atomicity by masking interrupts.

Each bus cycle is decoded into one named operation: `OP_IDLE`, `OP_WR_HI`, `OP_WR_LO`, `OP_RD_HI` or `OP_RD_LO`. These operations are selected with a unique case on the two strobes. There are no sequential states beyond the latch and the four registers. The latch moves from holding to reloaded on `OP_WR_HI`, and on `OP_RD_LO` aimed at the counter or the capture register.

Top module: `tmr_wide_bridge`

## Requirements
- R1: While `rst` is high, at each clock edge the counter, both compare registers, the capture register and the holding latch clear to 0x0000 / 0x00.
- R2: The address map is as follows. Bits `addr[2:1]` select the register: 0 is the counter, 1 is compare A, 2 is compare B and 3 is capture. Bit `addr[0]` = 1 selects the upper byte. A write (`wr_en` high) to an upper-byte address loads only the holding latch and leaves every 16-bit register unchanged.
- R3: A write to a lower-byte address updates the selected 16-bit register at that clock edge to {latch, `wdata`}.
- R4: A read (`rd_en` high, `wr_en` low) of the lower byte of the counter or the capture register returns that register's lower byte. At the clock edge, the read copies the register's upper byte into the latch. A read of their upper-byte address returns the latch, not the live upper byte.
- R5: A read of a compare register's upper byte returns its own live upper byte. A read of its lower byte returns its lower byte and leaves the latch unchanged.
- R6: The latch is shared. An upper-byte write or a latch-loading read of any register between the two halves of a sequence replaces the value that the completing access uses.
- R7: When `cnt_en` is high and no counter lower-byte write occurs, the counter increases by one per clock. It wraps from 0xFFFF to 0x0000.
- R8: A counter lower-byte write in the same cycle as `cnt_en` wins: the counter takes the written value, not the incremented one.
- R9: When `capt_stb` is high, the capture register loads the counter value present before that edge.
- R10: A capture lower-byte write in the same cycle as `capt_stb` wins over the strobe.
- R11: `rdata` is combinational from `addr` while `rd_en` is high, and is 0x00 while `rd_en` is low. When both strobes are high, the write acts and the read has no effect on the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Byte address (register index and upper/lower select) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| cnt_en | input | 1 | Counter increment enable |
| capt_stb | input | 1 | Capture strobe |
| rdata | output | 8 | Read data byte |
| cnt_val | output | 16 | Counter value |
| cmpa_val | output | 16 | Compare A value |
| cmpb_val | output | 16 | Compare B value |
| capt_val | output | 16 | Capture value |

## Verification
Two pairs of functions can land on the same edge.

The first pair is a CPU commit to the counter and the hardware increment. The bench keeps `cnt_en` high while it issues the counter lower-byte write. It then expects exactly the written word right after that edge and the word plus one an edge later.

The second pair is a CPU commit to the capture register and the capture strobe. The bench raises `capt_stb` during the capture lower-byte write and expects the bus word, not the counter value.

// File: rtl/twb_pkg.sv
package twb_pkg;
    localparam int BYTE_W = 8;
    localparam int WIDE_W = 2 * BYTE_W;
    localparam int ADDR_W = 3;
    localparam int N_CMP  = 2;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CMPA  = 2'd1,
        SEL_CMPB  = 2'd2,
        SEL_CAPT  = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_WR_HI,
        OP_WR_LO,
        OP_RD_HI,
        OP_RD_LO
    } bus_op_e;

    typedef struct packed {
        bus_op_e  op;
        reg_sel_e sel;
    } bus_req_t;

    function automatic logic uses_latch(reg_sel_e s);
        return (s == SEL_COUNT) || (s == SEL_CAPT);
    endfunction
endpackage

// File: rtl/twb_decode.sv
module twb_decode
    import twb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output bus_req_t          req
);
    always_comb begin
        req.sel = reg_sel_e'(addr[ADDR_W-1:1]);
        unique case ({wr_en, rd_en})
            2'b10, 2'b11: req.op = addr[0] ? OP_WR_HI : OP_WR_LO;
            2'b01:        req.op = addr[0] ? OP_RD_HI : OP_RD_LO;
            default:      req.op = OP_IDLE;
        endcase
    end
endmodule

// File: rtl/twb_latch.sv
module twb_latch
    import twb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [WIDE_W-1:0] cnt_q,
    input  logic [WIDE_W-1:0] capt_q,
    output logic [BYTE_W-1:0] latch_q
);
    logic [BYTE_W-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        unique case (req.op)
            OP_WR_HI: latch_d = wdata;
            OP_RD_LO: begin
                if (uses_latch(req.sel))
                    latch_d = (req.sel == SEL_COUNT) ? cnt_q[WIDE_W-1:BYTE_W]
                                                     : capt_q[WIDE_W-1:BYTE_W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= latch_d;
    end
endmodule

// File: rtl/twb_regs.sv
module twb_regs
    import twb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  bus_req_t                    req,
    input  logic [BYTE_W-1:0]           wdata,
    input  logic [BYTE_W-1:0]           latch_q,
    input  logic                        cnt_en,
    input  logic                        capt_stb,
    output logic [WIDE_W-1:0]           cnt_q,
    output logic [N_CMP-1:0][WIDE_W-1:0] cmp_q,
    output logic [WIDE_W-1:0]           capt_q
);
    logic [WIDE_W-1:0] commit_word;
    logic              commit;

    assign commit_word = {latch_q, wdata};
    assign commit      = (req.op == OP_WR_LO);

    always_ff @(posedge clk) begin
        if (rst)                                cnt_q <= '0;
        else if (commit && req.sel == SEL_COUNT) cnt_q <= commit_word;
        else if (cnt_en)                        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        localparam reg_sel_e MY_SEL = reg_sel_e'(2'(g + 1));
        always_ff @(posedge clk) begin
            if (rst)                             cmp_q[g] <= '0;
            else if (commit && req.sel == MY_SEL) cmp_q[g] <= commit_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                capt_q <= '0;
        else if (commit && req.sel == SEL_CAPT) capt_q <= commit_word;
        else if (capt_stb)                      capt_q <= cnt_q;
    end
endmodule

// File: rtl/tmr_wide_bridge.sv
module tmr_wide_bridge
    import twb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cnt_en,
    input  logic              capt_stb,
    output logic [BYTE_W-1:0] rdata,
    output logic [WIDE_W-1:0] cnt_val,
    output logic [WIDE_W-1:0] cmpa_val,
    output logic [WIDE_W-1:0] cmpb_val,
    output logic [WIDE_W-1:0] capt_val
);
    bus_req_t                     req;
    logic [BYTE_W-1:0]            latch_q;
    logic [N_CMP-1:0][WIDE_W-1:0] cmp_q;
    logic [WIDE_W-1:0]            sel_word;
    reg_sel_e                     rd_sel;

    twb_decode u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .req   (req)
    );

    twb_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wdata   (wdata),
        .cnt_q   (cnt_val),
        .capt_q  (capt_val),
        .latch_q (latch_q)
    );

    twb_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wdata    (wdata),
        .latch_q  (latch_q),
        .cnt_en   (cnt_en),
        .capt_stb (capt_stb),
        .cnt_q    (cnt_val),
        .cmp_q    (cmp_q),
        .capt_q   (capt_val)
    );

    assign cmpa_val = cmp_q[0];
    assign cmpb_val = cmp_q[1];
    assign rd_sel   = reg_sel_e'(addr[ADDR_W-1:1]);

    always_comb begin
        unique case (rd_sel)
            SEL_COUNT: sel_word = cnt_val;
            SEL_CMPA:  sel_word = cmp_q[0];
            SEL_CMPB:  sel_word = cmp_q[1];
            default:   sel_word = capt_val;
        endcase
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (!addr[0])                rdata = sel_word[BYTE_W-1:0];
            else if (uses_latch(rd_sel)) rdata = latch_q;
            else                         rdata = sel_word[WIDE_W-1:BYTE_W];
        end
    end
endmodule

// File: rtl/twb_checker.sv
module twb_checker
    import twb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BYTE_W-1:0] wdata,
    input logic              cnt_en,
    input logic              capt_stb,
    input logic [BYTE_W-1:0] rdata,
    input logic [BYTE_W-1:0] latch_q,
    input logic [WIDE_W-1:0] cnt_val,
    input logic [WIDE_W-1:0] cmpa_val,
    input logic [WIDE_W-1:0] cmpb_val,
    input logic [WIDE_W-1:0] capt_val
);
    logic wr_lo_cnt, wr_lo_cmpa, wr_lo_capt, rd_lo_cmp, wr_hi;
    assign wr_lo_cnt  = wr_en && addr == 3'd0;
    assign wr_lo_cmpa = wr_en && addr == 3'd2;
    assign wr_lo_capt = wr_en && addr == 3'd6;
    assign rd_lo_cmp  = rd_en && !wr_en && (addr == 3'd2 || addr == 3'd4);
    assign wr_hi      = wr_en && addr[0];

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt_val == '0 && cmpa_val == '0 && cmpb_val == '0 &&
                 capt_val == '0 && latch_q == '0));

    a_r2_hi_write_no_commit: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> ($stable(cmpa_val) && $stable(cmpb_val) && latch_q == $past(wdata)));

    a_r3_lo_write_commit: assert property (@(posedge clk) disable iff (rst)
        wr_lo_cmpa |=> cmpa_val == {$past(latch_q), $past(wdata)});

    a_r5_cmp_read_keeps_latch: assert property (@(posedge clk) disable iff (rst)
        rd_lo_cmp |=> $stable(latch_q));

    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !wr_lo_cnt) |=> cnt_val == $past(cnt_val) + 16'd1);

    a_r8_write_beats_count: assert property (@(posedge clk) disable iff (rst)
        wr_lo_cnt |=> cnt_val == {$past(latch_q), $past(wdata)});

    a_r9_capture_load: assert property (@(posedge clk) disable iff (rst)
        (capt_stb && !wr_lo_capt) |=> capt_val == $past(cnt_val));

    a_r10_write_beats_capture: assert property (@(posedge clk) disable iff (rst)
        wr_lo_capt |=> capt_val == {$past(latch_q), $past(wdata)});

    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0);
endmodule

bind tmr_wide_bridge twb_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .cnt_en   (cnt_en),
    .capt_stb (capt_stb),
    .rdata    (rdata),
    .latch_q  (latch_q),
    .cnt_val  (cnt_val),
    .cmpa_val (cmpa_val),
    .cmpb_val (cmpb_val),
    .capt_val (capt_val)
);

// File: tb/tmr_wide_bridge_tb_top.sv
`timescale 1ns/1ps
module tmr_wide_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  addr;
    logic        wr_en, rd_en, cnt_en, capt_stb;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [15:0] cnt_val, cmpa_val, cmpb_val, capt_val;
    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rb;

    localparam logic [2:0] A_CNT_LO = 3'd0, A_CNT_HI = 3'd1, A_CA_LO = 3'd2, A_CA_HI = 3'd3,
                           A_CB_LO = 3'd4, A_CB_HI = 3'd5, A_CP_LO = 3'd6, A_CP_HI = 3'd7;

    always #2.5 clk = ~clk;

    tmr_wide_bridge dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .cnt_en(cnt_en), .capt_stb(capt_stb), .rdata(rdata),
        .cnt_val(cnt_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val), .capt_val(capt_val)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 counter", cnt_val, 16'h0000);
        check("R1 compare A", cmpa_val, 16'h0000);
        check("R1 compare B", cmpb_val, 16'h0000);
        check("R1 capture", capt_val, 16'h0000);
        bus_rd(A_CNT_HI, rb);
        check("R1 latch via counter hi read", {8'h00, rb}, 16'h0000);
    endtask

    task automatic t_writes();
        bus_wr(A_CA_HI, 8'h12);
        check("R2 hi write leaves compare A", cmpa_val, 16'h0000);
        bus_wr(A_CA_LO, 8'h34);
        check("R3 compare A commit", cmpa_val, 16'h1234);
        bus_wr(A_CB_HI, 8'hAB);
        bus_wr(A_CB_LO, 8'hCD);
        check("R3 compare B commit", cmpb_val, 16'hABCD);
        bus_wr(A_CP_HI, 8'h5A);
        bus_wr(A_CP_LO, 8'h6B);
        check("R3 capture commit", capt_val, 16'h5A6B);
        bus_wr(A_CNT_HI, 8'h01);
        check("R2 hi write leaves counter", cnt_val, 16'h0000);
        bus_wr(A_CNT_LO, 8'hFF);
        check("R3 counter commit", cnt_val, 16'h01FF);
    endtask

    task automatic t_compare_read();
        bus_wr(A_CNT_HI, 8'h77);
        bus_rd(A_CA_HI, rb);
        check("R5 compare A hi live", {8'h00, rb}, 16'h0012);
        bus_rd(A_CB_LO, rb);
        check("R5 compare B lo", {8'h00, rb}, 16'h00CD);
        bus_rd(A_CNT_HI, rb);
        check("R5 latch untouched by compare read", {8'h00, rb}, 16'h0077);
    endtask

    task automatic t_latched_read();
        bus_rd(A_CNT_LO, rb);
        check("R4 counter lo read", {8'h00, rb}, 16'h00FF);
        bus_rd(A_CNT_HI, rb);
        check("R4 counter hi from latch", {8'h00, rb}, 16'h0001);
        bus_rd(A_CP_LO, rb);
        check("R4 capture lo read", {8'h00, rb}, 16'h006B);
        bus_rd(A_CNT_HI, rb);
        check("R6 counter hi read sees capture snapshot", {8'h00, rb}, 16'h005A);
    endtask

    task automatic t_corrupt_write();
        bus_wr(A_CA_HI, 8'hC3);
        bus_rd(A_CNT_LO, rb);
        bus_wr(A_CA_LO, 8'h3C);
        check("R6 interleaved read corrupts write", cmpa_val, 16'h013C);
    endtask

    task automatic t_count_wrap();
        bus_wr(A_CNT_HI, 8'hFF);
        bus_wr(A_CNT_LO, 8'hFE);
        @(negedge clk); cnt_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 cnt_en = 1'b0;
        check("R7 count and wrap", cnt_val, 16'h0001);
    endtask

    task automatic t_write_vs_count();
        @(negedge clk); cnt_en = 1'b1;
        bus_wr(A_CNT_HI, 8'h20);
        bus_wr(A_CNT_LO, 8'h00);
        check("R8 write wins over increment", cnt_val, 16'h2000);
        @(posedge clk); #1 cnt_en = 1'b0;
        check("R7 increment resumes", cnt_val, 16'h2001);
    endtask

    task automatic t_capture();
        @(negedge clk); capt_stb = 1'b1;
        @(posedge clk); #1 capt_stb = 1'b0;
        check("R9 capture loads counter", capt_val, 16'h2001);
        bus_wr(A_CP_HI, 8'h9A);
        @(negedge clk); capt_stb = 1'b1;
        bus_wr(A_CP_LO, 8'hBC);
        capt_stb = 1'b0;
        check("R10 write wins over capture", capt_val, 16'h9ABC);
    endtask

    task automatic t_rdata_idle();
        @(negedge clk); addr = A_CB_HI;
        #1 check("R11 rdata zero when idle", {8'h00, rdata}, 16'h0000);
        rd_en = 1'b1;
        #1 check("R11 rdata combinational", {8'h00, rdata}, 16'h00AB);
        rd_en = 1'b0;
    endtask

    initial begin
        fork
            begin
                rst = 1'b1; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
                cnt_en = 0; capt_stb = 0;
                repeat (3) @(posedge clk);
                #1 rst = 1'b0;
                t_reset();
                t_writes();
                t_compare_read();
                t_latched_read();
                t_corrupt_write();
                t_count_wrap();
                t_write_vs_count();
                t_capture();
                t_rdata_idle();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule